// File: doc/BRIEF.md
# Interrupt Priority Resolver with End-of-Interrupt Control

This block arbitrates among eight interrupt request lines. Requests are latched into a request register. An in-service register records which levels the processor is currently handling. A resolver, aware of the current rotation of priorities, picks the most urgent pending level. The interrupt output rises only when that level outranks everything already in service. The processor then runs an acknowledge handshake, and the block returns the chosen level.

Software steers the block through byte-wide command writes. One command family ends service on a level, either the most urgent one or a named one. It can also move the lowest-priority slot, so that priorities rotate. A mode can be switched on in which acknowledges end service automatically and rotate priority at the same moment. A second command family does three things: it picks which register the read port returns, it turns on special mask mode, and it arms a poll read. A poll read returns the pending level and acknowledges it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after it, int_out is 0, the in-service register is clear and ack_valid is 0. Reset leaves fixed priority (level 0 highest, level 7 lowest), rotation off, special mask mode off, poll off and the request register selected for reads.
- R2: A command write is taken as an end/priority command only when cmd_data[4:3] = 00. It is taken as a read/mode control word only when cmd_data[4:3] = 01 and cmd_data[7] = 0. All other writes change nothing.
- R3: One cycle after ack_req, ack_valid pulses and ack_level gives the highest-priority pending level. That level's request bit clears. Unless automatic end-of-interrupt is active, its in-service bit is set.
- R4: int_out is registered. It is 1 only when some request is pending and that request has strictly higher priority than every in-service level. It reflects the register state of the previous cycle.
- R5: Command code cmd_data[7:5] = 001 (non-specific end) clears the in-service bit of the highest-priority in-service level under the current rotation.
- R6: Code 011 (specific end) clears the in-service bit of the level in cmd_data[2:0]. Codes 001, 101, 100, 000 and 010 ignore cmd_data[2:0].
- R7: Code 101 does a non-specific end and also makes the cleared level the lowest priority.
- R8: Code 111 clears the named level and makes it the lowest priority. Code 110 only makes the named level the lowest priority. Code 010 changes nothing.
- R9: Code 100 switches on rotation with automatic end-of-interrupt, and code 000 switches it off. While it is on, an acknowledge sets no in-service bit and makes the acknowledged level the lowest priority.
- R10: A control word with bit 1 = 1 selects the read source from bit 0 (1 = in-service, 0 = request). rd_data carries the selected register one cycle after rd_en.
- R11: A control word with bit 6 = 1 loads special mask mode from bit 5. While that mode is on, in-service levels do not block int_out for lower-priority requests.
- R12: A control word with bit 2 = 1 arms a single poll read. The next read returns bit 7 = request present and bits 2:0 = highest pending level, or 0x00 when nothing is pending. Bits 6:3 are zero. The read acknowledges the level like R3 does, but gives no ack_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte |
| irq_in | input | 8 | Request lines, latched while high |
| ack_req | input | 1 | Acknowledge request |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_level | output | 3 | Acknowledged level |
| int_out | output | 1 | Interrupt to processor |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data (register or poll word) |

## Verification
A pulse on irq_in is latched at the next edge, and int_out responds one edge after that. A command write changes register state at its own edge, and int_out follows one edge later. ack_valid, ack_level and rd_data all appear one edge after their strobes. The bench drives at falling edges and keeps a reference model of the request, in-service and lowest-priority state. Each expected acknowledge or read result is queued when its strobe is driven. A monitor compares them at the falling edge after the result register loads. int_out is checked one full cycle after the model state changes.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [2:0] {
    OP_ROT_AUTO_OFF = 3'b000,
    OP_END_TOP      = 3'b001,
    OP_IDLE         = 3'b010,
    OP_END_NAMED    = 3'b011,
    OP_ROT_AUTO_ON  = 3'b100,
    OP_ROT_END_TOP  = 3'b101,
    OP_LOW_SET      = 3'b110,
    OP_ROT_END_NAMED= 3'b111
  } end_op_e;

  typedef struct packed {
    logic end_top;
    logic end_named;
    logic rot;
    logic low_set;
    logic auto_on;
    logic auto_off;
    logic smm_wr;
    logic smm_val;
    logic poll_arm;
    logic rsel_wr;
    logic rsel_isr;
  } cmd_dec_t;

endpackage

// File: rtl/irq_prio_cmd_dec.sv
module irq_prio_cmd_dec
  import irq_prio_pkg::*;
(
  input  logic       we,
  input  logic [7:0] data,
  output cmd_dec_t   dec
);

  always_comb begin
    dec = '0;
    if (we) begin
      if (data[4:3] == 2'b00) begin
        case (end_op_e'(data[7:5]))
          OP_END_TOP:       dec.end_top = 1'b1;
          OP_END_NAMED:     dec.end_named = 1'b1;
          OP_ROT_END_TOP:   begin dec.end_top = 1'b1;   dec.rot = 1'b1; end
          OP_ROT_END_NAMED: begin dec.end_named = 1'b1; dec.rot = 1'b1; end
          OP_LOW_SET:       dec.low_set = 1'b1;
          OP_ROT_AUTO_ON:   dec.auto_on = 1'b1;
          OP_ROT_AUTO_OFF:  dec.auto_off = 1'b1;
          default:          ;
        endcase
      end else if (data[4:3] == 2'b01 && !data[7]) begin
        dec.smm_wr   = data[6];
        dec.smm_val  = data[5];
        dec.poll_arm = data[2];
        dec.rsel_wr  = data[1];
        dec.rsel_isr = data[0];
      end
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_LVL = 8,
  parameter int LW    = $clog2(N_LVL)
) (
  input  logic [N_LVL-1:0] vec,
  input  logic [LW-1:0]    lowest,
  output logic             any,
  output logic [LW-1:0]    lvl
);

  logic [LW-1:0] idx;

  // Scan from the lowest-priority slot back to the highest; the last hit wins.
  always_comb begin
    any = |vec;
    lvl = '0;
    idx = '0;
    for (int k = N_LVL - 1; k >= 0; k--) begin
      idx = lowest + LW'(1) + LW'(k);
      if (vec[idx]) lvl = idx;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_LVL    = 8,
  parameter bit AUTO_EOI = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_we,
  input  logic [7:0]               cmd_data,
  input  logic [N_LVL-1:0]         irq_in,
  input  logic                     ack_req,
  output logic                     ack_valid,
  output logic [$clog2(N_LVL)-1:0] ack_level,
  output logic                     int_out,
  input  logic                     rd_en,
  output logic [7:0]               rd_data
);

  localparam int LW = $clog2(N_LVL);
  localparam logic [LW-1:0] LOW_RST = LW'(N_LVL - 1);

  logic [N_LVL-1:0] irr_q, isr_q;
  logic [LW-1:0]    low_q;
  logic             rot_auto_q, smm_q, poll_q, rsel_isr_q;
  logic             int_q, ack_valid_q;
  logic [LW-1:0]    ack_level_q;
  logic [7:0]       rd_data_q;

  cmd_dec_t dec;
  irq_prio_cmd_dec u_dec (.we(cmd_we), .data(cmd_data), .dec(dec));

  logic          pend_any, svc_any;
  logic [LW-1:0] pend_lvl, svc_lvl;

  irq_prio_pick #(.N_LVL(N_LVL), .LW(LW)) u_pend (
    .vec(irr_q), .lowest(low_q), .any(pend_any), .lvl(pend_lvl));
  irq_prio_pick #(.N_LVL(N_LVL), .LW(LW)) u_svc (
    .vec(isr_q), .lowest(low_q), .any(svc_any), .lvl(svc_lvl));

  function automatic logic [LW-1:0] rank_of(input logic [LW-1:0] l,
                                            input logic [LW-1:0] low);
    return l - low - LW'(1);
  endfunction

  logic             aeoi_eff, take, end_hit, int_nxt;
  logic [LW-1:0]    cmd_lvl, end_lvl, low_nxt;
  logic [N_LVL-1:0] isr_clr, isr_set, irr_clr;
  logic [7:0]       poll_word, rd_nxt;

  assign aeoi_eff = AUTO_EOI | rot_auto_q;
  assign take     = ack_req | (rd_en & poll_q);
  assign cmd_lvl  = cmd_data[LW-1:0];
  assign end_lvl  = dec.end_named ? cmd_lvl : svc_lvl;
  assign end_hit  = dec.end_named | (dec.end_top & svc_any);

  always_comb begin
    isr_clr = end_hit ? (N_LVL'(1) << end_lvl) : '0;
    isr_set = (take && pend_any && !aeoi_eff) ? (N_LVL'(1) << pend_lvl) : '0;
    irr_clr = (take && pend_any) ? (N_LVL'(1) << pend_lvl) : '0;

    low_nxt = low_q;
    if (take && pend_any && rot_auto_q) low_nxt = pend_lvl;
    if (dec.rot && end_hit)              low_nxt = end_lvl;
    if (dec.low_set)                     low_nxt = cmd_lvl;

    int_nxt = pend_any &&
              (smm_q || !svc_any ||
               (rank_of(pend_lvl, low_q) < rank_of(svc_lvl, low_q)));

    poll_word = '0;
    poll_word[7] = pend_any;
    poll_word[LW-1:0] = pend_lvl;
    if (poll_q)          rd_nxt = poll_word;
    else if (rsel_isr_q) rd_nxt = 8'(isr_q);
    else                 rd_nxt = 8'(irr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q       <= '0;
      isr_q       <= '0;
      low_q       <= LOW_RST;
      rot_auto_q  <= 1'b0;
      smm_q       <= 1'b0;
      poll_q      <= 1'b0;
      rsel_isr_q  <= 1'b0;
      int_q       <= 1'b0;
      ack_valid_q <= 1'b0;
      ack_level_q <= '0;
      rd_data_q   <= '0;
    end else begin
      irr_q       <= (irr_q & ~irr_clr) | irq_in;
      isr_q       <= (isr_q & ~isr_clr) | isr_set;
      low_q       <= low_nxt;
      int_q       <= int_nxt;
      ack_valid_q <= ack_req;
      if (ack_req) ack_level_q <= pend_lvl;
      if (rd_en)   rd_data_q   <= rd_nxt;
      if (dec.auto_on)       rot_auto_q <= 1'b1;
      else if (dec.auto_off) rot_auto_q <= 1'b0;
      if (dec.smm_wr)  smm_q      <= dec.smm_val;
      if (dec.rsel_wr) rsel_isr_q <= dec.rsel_isr;
      if (dec.poll_arm)             poll_q <= 1'b1;
      else if (rd_en && poll_q)     poll_q <= 1'b0;
    end
  end

  assign int_out   = int_q;
  assign ack_valid = ack_valid_q;
  assign ack_level = ack_level_q;
  assign rd_data   = rd_data_q;

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int N_LVL = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     int_out,
  input logic [N_LVL-1:0]         irr_q,
  input logic [N_LVL-1:0]         isr_q,
  input logic                     ack_valid,
  input logic [$clog2(N_LVL)-1:0] ack_level,
  input logic                     ack_req,
  input logic                     cmd_we,
  input logic [7:0]               cmd_data,
  input logic [$clog2(N_LVL)-1:0] low_q,
  input logic                     rd_en,
  input logic                     poll_q,
  input logic [7:0]               rd_data,
  input logic                     pend_any,
  input logic                     aeoi_eff
);

  localparam int LW = $clog2(N_LVL);
  localparam logic [7:0] MID_MASK = 8'h7F & ~8'((1 << LW) - 1);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!int_out && isr_q == '0 && !ack_valid));

  // R4
  int_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(irr_q != '0));

  // R3
  ack_from_req_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(ack_req));

  // R3
  ack_sets_service_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && $past(pend_any) && !$past(aeoi_eff) && !$past(cmd_we))
      |-> isr_q[ack_level]);

  // R5
  end_top_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_data[7:3] == 5'b00100 && !ack_req && !(rd_en && poll_q))
      |=> ($countones(isr_q) <= $countones($past(isr_q))));

  // R8
  low_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_data[7:3] == 5'b11000) |=> (low_q == $past(cmd_data[LW-1:0])));

  // R12
  poll_word_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && poll_q) |-> ((rd_data & MID_MASK) == 8'h00));

endmodule

bind irq_prio_ctrl irq_prio_chk #(.N_LVL(N_LVL)) u_chk (
  .clk(clk), .rst(rst), .int_out(int_out), .irr_q(irr_q), .isr_q(isr_q),
  .ack_valid(ack_valid), .ack_level(ack_level), .ack_req(ack_req),
  .cmd_we(cmd_we), .cmd_data(cmd_data), .low_q(low_q), .rd_en(rd_en),
  .poll_q(poll_q), .rd_data(rd_data), .pend_any(pend_any), .aeoi_eff(aeoi_eff)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst = 1'b1;
  logic       cmd_we = 1'b0, ack_req = 1'b0, rd_en = 1'b0;
  logic [7:0] cmd_data = '0, irq_in = '0;
  logic       ack_valid, int_out;
  logic [2:0] ack_level;
  logic [7:0] rd_data;

  irq_prio_ctrl dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .irq_in(irq_in), .ack_req(ack_req), .ack_valid(ack_valid),
    .ack_level(ack_level), .int_out(int_out), .rd_en(rd_en), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int ack_q[$], ack_tag[$], rd_tag[$];
  logic [7:0] rd_q[$];
  logic rd_seen = 1'b0;

  // reference model
  logic [7:0] m_irr = '0, m_isr = '0;
  int m_low = 7;
  bit m_rot = 0, m_smm = 0, m_risr = 0, m_poll = 0;

  function automatic int rank(int l);
    return (l - m_low - 1) & 7;
  endfunction

  function automatic int top_of(logic [7:0] v);
    int best = -1;
    for (int i = 0; i < 8; i++)
      if (v[i] && (best < 0 || rank(i) < rank(best))) best = i;
    return best;
  endfunction

  task automatic check(int tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_take();
    int p = top_of(m_irr);
    if (p >= 0) begin
      m_irr[p] = 1'b0;
      if (m_rot) m_low = p;
      else m_isr[p] = 1'b1;
    end
  endtask

  task automatic raise(logic [7:0] m);
    irq_in = m;
    @(negedge clk);
    irq_in = '0;
    m_irr = m_irr | m;
  endtask

  task automatic do_ack(int tag);
    int p = top_of(m_irr);
    ack_q.push_back(p < 0 ? 0 : p);
    ack_tag.push_back(tag);
    model_take();
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  task automatic cmd(logic [7:0] d);
    int s = top_of(m_isr);
    int l = int'(d[2:0]);
    if (d[4:3] == 2'b00) begin
      case (d[7:5])
        3'b001: if (s >= 0) m_isr[s] = 1'b0;
        3'b011: m_isr[l] = 1'b0;
        3'b101: if (s >= 0) begin m_isr[s] = 1'b0; m_low = s; end
        3'b111: begin m_isr[l] = 1'b0; m_low = l; end
        3'b110: m_low = l;
        3'b100: m_rot = 1;
        3'b000: m_rot = 0;
        default: ;
      endcase
    end else if (d[4:3] == 2'b01 && !d[7]) begin
      if (d[6]) m_smm = d[5];
      if (d[2]) m_poll = 1;
      if (d[1]) m_risr = d[0];
    end
    cmd_we = 1'b1;
    cmd_data = d;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic rd(int tag);
    logic [7:0] e;
    if (m_poll) begin
      int p = top_of(m_irr);
      e = (p < 0) ? 8'h00 : {1'b1, 4'b0000, 3'(p)};
      model_take();
      m_poll = 0;
    end else begin
      e = m_risr ? m_isr : m_irr;
    end
    rd_q.push_back(e);
    rd_tag.push_back(tag);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_int(int tag);
    int p, s;
    bit e;
    @(negedge clk);
    p = top_of(m_irr);
    s = m_smm ? -1 : top_of(m_isr);
    e = (p >= 0) && (s < 0 || rank(p) < rank(s));
    check(tag, int'(int_out), int'(e));
  endtask

  // monitor
  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (!rst) begin
      if (ack_valid) begin
        if (ack_q.size() == 0) check(3, 1, 0); // R3 unexpected acknowledge
        else check(ack_tag.pop_front(), int'(ack_level), ack_q.pop_front());
      end
      if (rd_seen) begin
        if (rd_q.size() == 0) check(10, 1, 0); // R10 unexpected read
        else check(rd_tag.pop_front(), int'(rd_data), int'(rd_q.pop_front()));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_int(1);                 // R1 idle after reset
    rd(1);                      // R1 request register reads zero

    raise(8'h28);               // levels 3 and 5
    chk_int(4);                 // R4
    do_ack(3);                  // R3 expects 3
    cmd(8'h0B); rd(10);         // R10 in-service = 0x08
    cmd(8'h0A); rd(10);         // R10 request = 0x20
    chk_int(4);                 // R4 level 5 blocked by 3

    raise(8'h02);
    chk_int(4);                 // R4 level 1 beats 3
    do_ack(3);                  // R3 expects 1
    cmd(8'h0B);
    cmd(8'h30); rd(2);          // R2 bits 4:3=10 ignored
    cmd(8'h25); rd(5);          // R5 clears level 1, R6 bits 2:0 ignored
    cmd(8'h63); rd(6);          // R6 clears level 3
    chk_int(4);

    cmd(8'hC4);                 // R8 level 4 lowest
    raise(8'h21);
    do_ack(8);                  // R8 expects 5
    do_ack(8);                  // expects 0
    cmd(8'hA0); rd(7);          // R7 clears 5, 5 becomes lowest
    raise(8'h50);
    do_ack(7);                  // R7 expects 6
    cmd(8'hE0);                 // R8 clears 0, 0 lowest
    do_ack(8);                  // expects 4
    cmd(8'h47); rd(8);          // R8 idle code leaves 0x50
    cmd(8'h64); cmd(8'h66); cmd(8'hC7);

    raise(8'h01);
    do_ack(3);
    raise(8'h04);
    chk_int(4);                 // R4 level 2 blocked
    cmd(8'h68); chk_int(11);    // R11 special mask on
    cmd(8'h48); chk_int(11);    // R11 special mask off
    do_ack(3);
    cmd(8'h60); cmd(8'h62);

    cmd(8'h80);                 // R9 automatic end with rotation
    raise(8'h11);
    do_ack(9); do_ack(9);       // R9 expects 0 then 4
    rd(9);                      // R9 nothing in service
    cmd(8'h00);
    raise(8'h04);
    do_ack(9); rd(9);           // R9 in-service set again
    cmd(8'h62);

    raise(8'h48);
    cmd(8'h0C); rd(12);         // R12 poll returns 0x86
    rd(12);                     // R12 poll consumed, in-service 0x40
    do_ack(3);
    cmd(8'h0C); rd(12);         // R12 nothing pending
    chk_int(4);

    repeat (3) @(negedge clk);
    check(3, ack_q.size(), 0);  // R3 every acknowledge seen
    check(10, rd_q.size(), 0);  // R10 every read seen
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule